// File: doc/BRIEF.md
# Configuration Image Framer

This block sits on a byte stream that a host-side transfer path delivers through a valid/ready handshake. Somewhere in the stream is an FPGA configuration image. The block discards every byte until it sees the four-byte sync word that opens an image. It then sends the image downstream, starting with the sync word itself, and stops after the three-byte wake-up command that closes it.

Matching happens on the fly, one byte per accepted beat. The block keeps no copy of the stream. Because the sync word has already been consumed by the time it is recognised, the block re-emits it from constants before it opens the pass-through path. Downstream logic gets the following:
- a one-cycle pulse when an image starts;
- a one-cycle pulse when an image ends;
- a running byte count that ends up equal to the image length;
- a marker on the last byte of every 512-byte chunk, which also marks the final short chunk.

A synchronous abort drops the block back into searching.

Top module: `bitstream_marker_detector`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `in_ready` is 1, `out_valid` is 0, `byte_count` is 0, and both pulses are 0.
- R2: In the searching state, `in_ready` is 1 and `out_valid` is 0. Every byte accepted there is discarded and never shows up on `out_data`.
- R3: The image start is the accepted byte sequence 0x7E, 0xAA, 0x99, 0x7E. A partial match that breaks must still find an overlapping occurrence, for example 0x7E 0x7E 0xAA 0x99 0x7E. `start_pulse` is high for exactly one cycle, the cycle after the edge that accepted the fourth sync byte.
- R4: The first four bytes sent out are 0x7E, 0xAA, 0x99, 0x7E. `out_valid` is 1 and `in_ready` is 0 while they are sent, and each one waits for `out_ready`.
- R5: After the sync word is replayed, forwarding is combinational: `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`.
- R6: The image ends with the forwarded byte sequence 0x01, 0x06, 0x00, with overlaps handled (for example 0x01 0x01 0x06 0x00). The 0x00 is forwarded with `out_image_last` high. `end_pulse` is high for one cycle after that byte is transferred, and the block is then searching again.
- R7: `byte_count` goes to 0 when the sync word is found. It rises by 1 for each transferred output byte. After the end it holds the total image length, including the sync word and the end command, until the next start or abort.
- R8: `out_chunk_end` is high on any output byte that is the 512th, 1024th, … byte of the image, counting the first sync byte as byte 1. It is also high on the final byte of the image.
- R9: When `abort` is high at an edge, the block is searching on the next cycle, with `byte_count` at 0 and any partial match forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| abort | input | 1 | Synchronous return to searching |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_ready | input | 1 | Downstream can take a byte |
| out_chunk_end | output | 1 | Last byte of a 512-byte chunk or of the image |
| out_image_last | output | 1 | Final byte of the image (the 0x00 of the end command) |
| start_pulse | output | 1 | One-cycle pulse: sync word found |
| end_pulse | output | 1 | One-cycle pulse: end command forwarded |
| byte_count | output | COUNT_W | Bytes forwarded since the last start |

## Verification
The bench attacks overlapping prefixes of both markers, such as a repeated 0x7E ahead of the sync word and 0x01 0x06 0x01 0x06 0x00 at the tail. A matcher that only resets to zero on a mismatch would miss the image or run past its end. It holds `out_ready` low in random patterns during the sync replay and during forwarding. A design that skipped or repeated a replayed byte, or accepted input while replaying, would then shift or lose data against the reference queue. Long images cross several 512-byte boundaries, so an off-by-one in the chunk position shows up as a misplaced chunk marker. An abort in the middle of an image followed by a fresh image checks that a stale count or stale match depth is never carried over.

// File: rtl/bsd_pkg.sv
// Shared constants and types for the configuration image framer.
// Assumes byte-wide streams; patterns are stored first byte in the MSBs.
package bsd_pkg;

    // Sync word that opens an image, first byte in bits [31:24].
    localparam int              SYNC_LEN  = 4;
    localparam logic [31:0]     SYNC_WORD = 32'h7EAA_997E;

    // Wake-up command that closes an image, first byte in bits [23:16].
    localparam int              WAKE_LEN  = 3;
    localparam logic [23:0]     WAKE_CMD  = 24'h01_0600;

    // Framer states.
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_REPLAY  = 2'd1,
        ST_FORWARD = 2'd2
    } bsd_state_e;

endpackage

// File: rtl/bsd_seq_matcher.sv
// Streaming matcher for a fixed byte pattern.
// It keeps the length of the longest pattern prefix that ends at the last
// stepped byte. On a mismatch it falls back to the longest prefix that is
// still a suffix, so overlapping occurrences are found.
// complete_o is combinational: the byte on byte_i would finish the pattern.
// After a completing step the depth returns to zero.
module bsd_seq_matcher #(
    parameter int               LEN     = 4,
    parameter logic [8*LEN-1:0] PATTERN = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [7:0] byte_i,
    output logic       complete_o
);

    localparam int DEPTH_W = $clog2(LEN + 1);

    logic [DEPTH_W-1:0] depth_q;
    int                 nxt;

    // Byte idx of the pattern, counted from the first byte.
    function automatic logic [7:0] pat_byte(input int idx);
        return PATTERN[(LEN-1-idx)*8 +: 8];
    endfunction

    // Longest prefix that ends on byte b after k bytes had matched.
    function automatic int next_depth(input int k, input logic [7:0] b);
        int r;
        r = 0;
        for (int j = 1; j <= LEN; j++) begin
            if (j <= k + 1) begin
                bit ok;
                ok = (pat_byte(j-1) == b);
                for (int i = 0; i < j - 1; i++) begin
                    if (pat_byte(i) != pat_byte(k - j + 1 + i)) ok = 1'b0;
                end
                if (ok) r = j;
            end
        end
        return r;
    endfunction

    // Work out the next depth for the byte now presented.
    always_comb begin
        nxt        = next_depth(int'(depth_q), byte_i);
        complete_o = (nxt == LEN);
    end

    // Hold the current match depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (clear_i) begin
            depth_q <= '0;
        end else if (step_i) begin
            depth_q <= complete_o ? '0 : DEPTH_W'(nxt);
        end
    end

endmodule

// File: rtl/bsd_span_counter.sv
// Image length counter and position within the current chunk.
// restart_i wins over beat_i. The length counter wraps at 2**COUNT_W.
// chunk_wrap_o is high while the next beat is the last byte of a chunk.
module bsd_span_counter #(
    parameter int COUNT_W     = 24,
    parameter int CHUNK_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               beat_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               chunk_wrap_o
);

    localparam int POS_W = $clog2(CHUNK_BYTES);

    logic [POS_W-1:0] pos_q;

    // Flag the last byte slot of a chunk.
    always_comb chunk_wrap_o = (pos_q == POS_W'(CHUNK_BYTES - 1));

    // Count image bytes and the position inside the chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            pos_q   <= '0;
        end else if (restart_i) begin
            count_o <= '0;
            pos_q   <= '0;
        end else if (beat_i) begin
            count_o <= count_o + COUNT_W'(1);
            pos_q   <= chunk_wrap_o ? '0 : pos_q + POS_W'(1);
        end
    end

endmodule

// File: rtl/bitstream_marker_detector.sv
// Finds a configuration image in a byte stream and forwards it.
// SEARCH : consumes and drops bytes and looks for the sync word.
// REPLAY : sends the consumed sync word out of constants; input stalls.
// FORWARD: passes bytes straight through and looks for the wake command.
// Assumes the downstream side honours valid/ready, with a transfer on
// valid && ready. abort is synchronous and has priority over all else.
module bitstream_marker_detector #(
    parameter int COUNT_W     = 24,
    parameter int CHUNK_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               out_chunk_end,
    output logic               out_image_last,
    output logic               start_pulse,
    output logic               end_pulse,
    output logic [COUNT_W-1:0] byte_count
);

    import bsd_pkg::*;

    localparam int IDX_W = $clog2(SYNC_LEN);

    bsd_state_e       state_q;
    logic [IDX_W-1:0] replay_idx_q;
    logic             out_xfer;
    logic             sync_step;
    logic             sync_complete;
    logic             sync_found;
    logic             wake_step;
    logic             wake_clear;
    logic             wake_complete;
    logic             wake_found;
    logic             span_restart;
    logic             chunk_wrap;

    // Handshake and data steering for each state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        case (state_q)
            ST_SEARCH: begin
                in_ready = 1'b1;
            end
            ST_REPLAY: begin
                out_valid = 1'b1;
                out_data  = SYNC_WORD[8*(SYNC_LEN-1-int'(replay_idx_q)) +: 8];
            end
            ST_FORWARD: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
            default: begin
                in_ready = 1'b1;
            end
        endcase
    end

    // Events derived from the handshake and the two matchers.
    always_comb begin
        out_xfer       = out_valid && out_ready;
        sync_step      = (state_q == ST_SEARCH) && in_valid;
        sync_found     = sync_step && sync_complete;
        wake_step      = (state_q == ST_FORWARD) && out_xfer;
        wake_found     = wake_step && wake_complete;
        wake_clear     = abort || sync_found;
        span_restart   = abort || sync_found;
        out_image_last = (state_q == ST_FORWARD) && in_valid && wake_complete;
        out_chunk_end  = out_valid && (chunk_wrap || out_image_last);
    end

    // Sync word matcher on accepted search bytes.
    bsd_seq_matcher #(
        .LEN     (SYNC_LEN),
        .PATTERN (SYNC_WORD)
    ) u_sync_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (abort),
        .step_i     (sync_step),
        .byte_i     (in_data),
        .complete_o (sync_complete)
    );

    // Wake command matcher on forwarded bytes.
    bsd_seq_matcher #(
        .LEN     (WAKE_LEN),
        .PATTERN (WAKE_CMD)
    ) u_wake_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (wake_clear),
        .step_i     (wake_step),
        .byte_i     (in_data),
        .complete_o (wake_complete)
    );

    // Image length and chunk position.
    bsd_span_counter #(
        .COUNT_W     (COUNT_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_span (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (span_restart),
        .beat_i       (out_xfer && !abort),
        .count_o      (byte_count),
        .chunk_wrap_o (chunk_wrap)
    );

    // State sequencing and replay index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_SEARCH;
            replay_idx_q <= '0;
        end else if (abort) begin
            state_q      <= ST_SEARCH;
            replay_idx_q <= '0;
        end else begin
            case (state_q)
                ST_SEARCH: begin
                    if (sync_found) begin
                        state_q      <= ST_REPLAY;
                        replay_idx_q <= '0;
                    end
                end
                ST_REPLAY: begin
                    if (out_ready) begin
                        if (replay_idx_q == IDX_W'(SYNC_LEN - 1)) begin
                            state_q      <= ST_FORWARD;
                            replay_idx_q <= '0;
                        end else begin
                            replay_idx_q <= replay_idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_FORWARD: begin
                    if (wake_found) state_q <= ST_SEARCH;
                end
                default: state_q <= ST_SEARCH;
            endcase
        end
    end

    // One-cycle start and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            end_pulse   <= 1'b0;
        end else begin
            start_pulse <= !abort && sync_found;
            end_pulse   <= !abort && wake_found;
        end
    end

endmodule

// File: rtl/bsd_checker.sv
// Property checker for the image framer, attached by bind.
// It looks only at the top-level ports.
module bsd_checker #(
    parameter int COUNT_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               abort,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [7:0]         out_data,
    input logic               out_ready,
    input logic               out_chunk_end,
    input logic               out_image_last,
    input logic               start_pulse,
    input logic               end_pulse,
    input logic [COUNT_W-1:0] byte_count
);

    // R3: the start pulse never lasts two cycles.
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R4: replay begins with the first sync byte while input is stalled.
    p_replay_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (out_valid && !in_ready && out_data == 8'h7E));

    // R5: input is never taken while the downstream side stalls and data is offered.
    p_no_accept_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R6: a transferred final byte is followed by the end pulse.
    p_end_follows_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_image_last && !abort) |=> end_pulse);

    // R2: the end pulse coincides with searching, so nothing is offered.
    p_search_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> (!out_valid && in_ready));

    // R7: the count holds when nothing moves.
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && !(out_valid && out_ready) && !(in_valid && in_ready))
        |=> $stable(byte_count));

    // R7: each output transfer adds one.
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && out_valid && out_ready)
        |=> (byte_count == COUNT_W'($past(byte_count) + 1)));

    // R8: the final byte always closes a chunk.
    p_last_closes_chunk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_image_last) |-> out_chunk_end);

    // R9: abort leaves a cleared, searching block.
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (byte_count == '0 && in_ready && !out_valid));

endmodule

bind bitstream_marker_detector bsd_checker #(.COUNT_W(COUNT_W)) u_bsd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort          (abort),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_ready      (out_ready),
    .out_chunk_end  (out_chunk_end),
    .out_image_last (out_image_last),
    .start_pulse    (start_pulse),
    .end_pulse      (end_pulse),
    .byte_count     (byte_count)
);

// File: tb/tb_bitstream_marker_detector.sv
`timescale 1ns/1ps
// Bench for the image framer: a behavioural reference model (history
// queues, integers) is compared against the ports on every clock.
module tb_bitstream_marker_detector;

    localparam int COUNT_W = 24;
    localparam int CHUNK   = 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               abort = 1'b0;
    logic               in_valid = 1'b0;
    logic [7:0]         in_data = 8'h00;
    logic               in_ready;
    logic               out_valid;
    logic [7:0]         out_data;
    logic               out_ready = 1'b1;
    logic               out_chunk_end;
    logic               out_image_last;
    logic               start_pulse;
    logic               end_pulse;
    logic [COUNT_W-1:0] byte_count;

    int tests = 0;
    int fails = 0;

    // Reference model state.
    int         m_state = 0;   // 0 search, 1 replay, 2 forward
    int         m_idx   = 0;
    int         m_count = 0;
    int         m_chunk = 0;
    bit         m_start = 0;
    bit         m_end   = 0;
    logic [7:0] sync_hist[$];
    logic [7:0] end_hist[$];
    logic [7:0] sync_b[4] = '{8'h7E, 8'hAA, 8'h99, 8'h7E};

    always #4 clk = ~clk;

    bitstream_marker_detector #(.COUNT_W(COUNT_W), .CHUNK_BYTES(CHUNK)) dut (
        .clk(clk), .rst_n(rst_n), .abort(abort),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .out_chunk_end(out_chunk_end), .out_image_last(out_image_last),
        .start_pulse(start_pulse), .end_pulse(end_pulse), .byte_count(byte_count)
    );

    task automatic chk(input string tag, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Compare one cycle against the model, then advance the model across the edge.
    task automatic step(output bit acc);
        bit e_rdy, e_vld, e_last, e_chk;
        logic [7:0] e_dat;
        bit c_vld, c_rdy, c_abt;
        logic [7:0] c_dat;
        bit hit;
        #1;
        e_rdy = 0; e_vld = 0; e_last = 0; e_dat = 8'h00;
        if (m_state == 0) begin
            e_rdy = 1;
        end else if (m_state == 1) begin
            e_vld = 1; e_dat = sync_b[m_idx];
        end else begin
            e_rdy = out_ready; e_vld = in_valid; e_dat = in_data;
            e_last = in_valid && end_hist.size() >= 2 &&
                     end_hist[end_hist.size()-2] == 8'h01 &&
                     end_hist[end_hist.size()-1] == 8'h06 && in_data == 8'h00;
        end
        e_chk = e_vld && (m_chunk == CHUNK-1 || e_last);
        chk(m_state == 2 ? "R5" : "R2", "in_ready",  in_ready,  e_rdy);
        chk(m_state == 2 ? "R5" : "R2", "out_valid", out_valid, e_vld);
        if (e_vld) begin
            chk(m_state == 1 ? "R4" : "R5", "out_data", out_data, e_dat);
            chk("R6", "out_image_last", out_image_last, e_last);
            chk("R8", "out_chunk_end", out_chunk_end, e_chk);
        end
        chk("R3", "start_pulse", start_pulse, m_start);
        chk("R6", "end_pulse", end_pulse, m_end);
        chk("R7", "byte_count", byte_count, m_count);
        acc = in_valid && e_rdy;
        c_vld = in_valid; c_rdy = out_ready; c_abt = abort; c_dat = in_data;
        @(posedge clk);
        m_start = 0; m_end = 0;
        if (c_abt) begin
            m_state = 0; m_idx = 0; m_count = 0; m_chunk = 0;
            sync_hist.delete(); end_hist.delete();
        end else if (m_state == 0) begin
            if (c_vld) begin
                sync_hist.push_back(c_dat);
                if (sync_hist.size() > 4) void'(sync_hist.pop_front());
                hit = sync_hist.size() == 4;
                for (int i = 0; i < 4; i++) if (hit && sync_hist[i] != sync_b[i]) hit = 0;
                if (hit) begin
                    m_state = 1; m_idx = 0; m_count = 0; m_chunk = 0; m_start = 1;
                    sync_hist.delete(); end_hist.delete();
                end
            end
        end else if (m_state == 1) begin
            if (c_rdy) begin
                m_count++; m_chunk = (m_chunk + 1) % CHUNK;
                if (m_idx == 3) begin m_state = 2; m_idx = 0; end
                else m_idx++;
            end
        end else begin
            if (c_vld && c_rdy) begin
                m_count++; m_chunk = (m_chunk + 1) % CHUNK;
                end_hist.push_back(c_dat);
                if (end_hist.size() > 3) void'(end_hist.pop_front());
                if (end_hist.size() == 3 && end_hist[0] == 8'h01 &&
                    end_hist[1] == 8'h06 && end_hist[2] == 8'h00) begin
                    m_state = 0; m_end = 1;
                    sync_hist.delete(); end_hist.delete();
                end
            end
        end
        @(negedge clk);
    endtask

    // Push a byte queue through with given valid and ready percentages.
    task automatic send(input logic [7:0] q[$], input int vpct, input int rpct);
        bit acc;
        while (q.size() > 0) begin
            in_valid  = ($urandom_range(99) < vpct);
            in_data   = q[0];
            out_ready = ($urandom_range(99) < rpct);
            step(acc);
            if (acc) void'(q.pop_front());
        end
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        bit acc;
        out_ready = 1; in_valid = 0;
        for (int i = 0; i < n; i++) step(acc);
    endtask

    // Image body bytes that cannot form the end command (no 0x00).
    function automatic void add_body(ref logic [7:0] q[$], input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom_range(255));
            if (b == 8'h00) b = 8'h55;
            q.push_back(b);
        end
    endfunction

    // Garbage that cannot start a sync word (no 0x7E).
    function automatic void add_junk(ref logic [7:0] q[$], input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom_range(255));
            if (b == 8'h7E) b = 8'h3C;
            q.push_back(b);
        end
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        bit acc;
        int len;
        // R1: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset in_ready", in_ready, 1);
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset byte_count", byte_count, 0);
        chk("R1", "reset pulses", {start_pulse, end_pulse}, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "post-reset in_ready", in_ready, 1);
        chk("R1", "post-reset out_valid", out_valid, 0);
        @(negedge clk);

        // R2 R3 R5 R6: plain image with junk before and after.
        q.delete(); add_junk(q, 20);
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 30);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        add_junk(q, 10);
        send(q, 100, 100);
        idle(3);

        // R3 R6: overlapping starts and ends, near-miss end inside body.
        q.delete();
        q.push_back(8'h7E); q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 5);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h05);
        q.push_back(8'h01); q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h7E); q.push_back(8'hAA);
        q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 7);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        send(q, 100, 100);
        idle(3);

        // R4 R5: backpressure and gaps through replay and forwarding.
        for (int k = 0; k < 4; k++) begin
            q.delete(); add_junk(q, 5);
            q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
            add_body(q, 40 + k * 13);
            q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
            send(q, 70, 60);
            idle(2);
        end

        // R7 R8: long image across several chunks; length checked directly.
        q.delete();
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 1300);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        len = q.size();
        send(q, 90, 85);
        idle(4);
        chk("R7", "final length held", byte_count, len);

        // R8: image of exactly 512 bytes, final byte is also chunk end.
        q.delete();
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, CHUNK - 7);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        send(q, 100, 100);
        idle(2);
        chk("R8", "512-byte image length", byte_count, CHUNK);

        // R9: abort in the middle of forwarding, then a fresh image.
        q.delete();
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 20);
        q.push_back(8'h01); q.push_back(8'h06);
        send(q, 100, 100);
        abort = 1; step(acc); abort = 0;
        chk("R9", "abort count", byte_count, 0);
        chk("R9", "abort in_ready", in_ready, 1);
        chk("R9", "abort out_valid", out_valid, 0);
        // A lone 0x00 after abort must not end anything: block is searching.
        q.delete(); q.push_back(8'h00); q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99);
        send(q, 100, 100);
        abort = 1; step(acc); abort = 0;
        // Partial sync before abort is forgotten: 0x7E alone must not complete it.
        q.delete(); q.push_back(8'h7E);
        add_junk(q, 3);
        q.push_back(8'h7E); q.push_back(8'hAA); q.push_back(8'h99); q.push_back(8'h7E);
        add_body(q, 9);
        q.push_back(8'h01); q.push_back(8'h06); q.push_back(8'h00);
        send(q, 80, 80);
        idle(3);
        chk("R9", "image after abort length", byte_count, 16);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule